// File: doc/BRIEF.md
# Row Erase-and-Program Sequencer

This block sits on the programmer side of a two-wire serial programming link. It takes one row of 32 fourteen-bit words out of a local buffer and writes it into a target's flash, then reads the row back to confirm it. A bit-level serial driver beneath it does the shifting. The sequencer hands that driver one command at a time over a request/acknowledge handshake and leaves the required idle gap between commands. It also counts out the erase and program waits, which the target does not time for itself, with a prescaled timer.

A run begins with a one-cycle `start` pulse, a row address and a supply flag. The sequencer asks for a re-entry into programming mode, which resets the target's address pointer. It sends one priming load, steps the pointer to the row base, and erases the row. The row is then written in eight groups of four words. After that the sequencer re-enters the mode, steps to the row again, and compares every word it reads back. When it finishes it raises `done` for one cycle. A mismatch stops the run at once and records the failing address.

Top module: `rowprog_seq`

## Requirements
- R1: After reset and whenever the block is idle, `busy`, `done`, `drv_req` and `reenter_req` are all 0.
- R2: A `start` pulse is taken only while the block is idle. A `start` during a run has no effect on the commands that follow, and `row_addr` and `low_vdd` are captured when a run is accepted.
- R3: Every run opens with a re-entry request. Next comes one load command (code 000010, data 0x3FFF), sent before any erase or program command. Then comes one increment (000110) for each word below the row base. The base is `row_addr` with its low 5 bits cleared.
- R4: The row is erased with a begin-erase command (001000). A timed wait follows, and then an end-programming command (010111).
- R5: Data is written in eight groups. Each group is: load, increment, load, increment, load, increment, load, begin-program (011000), timed wait, end-programming, increment. The load data is buffer entries 0 to 31 in order, with `buf_idx` naming the entry.
- R6: Each timed wait holds the command link idle for at least TICKS_HI×TICK_DIV clock cycles when `low_vdd` was 0 at start, and for at least TICKS_LO×TICK_DIV cycles when it was 1.
- R7: After every acknowledged command, at least GAP_HI idle cycles (GAP_LO at low supply) pass before the next command is requested. A command that follows a re-entry is exempt.
- R8: `drv_req`, `drv_op` and `drv_arg` stay constant from the cycle a command is requested until the cycle `drv_ack` is seen.
- R9: The check-back phase issues a second re-entry, which is held until `reenter_ack` and never overlaps a command request. It then repeats the base increments and issues read commands (000100) with one increment between successive reads. Each `drv_rdata` is compared with the matching buffer word.
- R10: On the first read-back mismatch the run ends with `done`, `verify_err`=1 and `fail_addr` set to the row base plus the word index. No further command is issued.
- R11: A row that reads back correctly ends with a single-cycle `done` and `verify_err`=0. The block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one row cycle (ignored while busy) |
| row_addr | input | ADDR_W | Word address inside the target row |
| low_vdd | input | 1 | 1 selects the low-supply waits and gaps |
| buf_idx | output | log2(ROW_WORDS) | Index of the buffer word being requested |
| buf_word | input | 14 | Buffer word at `buf_idx` |
| reenter_req | output | 1 | Ask for re-entry into programming mode |
| reenter_ack | input | 1 | Re-entry finished, target pointer is zero |
| drv_req | output | 1 | Command request to the serial driver |
| drv_op | output | 6 | Command code |
| drv_arg | output | 14 | Data word carried with the command |
| drv_ack | input | 1 | Driver finished the command |
| drv_rdata | input | 14 | Word read by a read command, valid with `drv_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| verify_err | output | 1 | Last run found a read-back mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatching word |

## Verification
The hardest case to reach from the ports is a mismatch partway through read-back, once a full erase and eight program groups have already gone through correctly. The bench's target model keeps a word store and a pointer of its own, and it can flip one bit in the reply for a chosen absolute address. That fault lands on the first, a middle and the last word of a row. A second hard case is a `start` pulse with a different address arriving mid-run. The bench checks this by comparing every later command against a list it built before the run began.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;

    localparam int WORD_W      = 14;
    localparam int CMD_W       = 6;
    localparam int GROUP_WORDS = 4;

    localparam logic [CMD_W-1:0] OP_LOAD  = 6'b000010;
    localparam logic [CMD_W-1:0] OP_READ  = 6'b000100;
    localparam logic [CMD_W-1:0] OP_INCR  = 6'b000110;
    localparam logic [CMD_W-1:0] OP_ERASE = 6'b001000;
    localparam logic [CMD_W-1:0] OP_PROG  = 6'b011000;
    localparam logic [CMD_W-1:0] OP_STOP  = 6'b010111;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [WORD_W-1:0] arg;
    } xfer_t;

    typedef enum logic [4:0] {
        ST_IDLE, ST_ENTER, ST_PRIME, ST_SEEK,
        ST_ERASE, ST_EWAIT, ST_ECLOSE,
        ST_LOAD, ST_LSTEP, ST_PROG, ST_PWAIT, ST_PCLOSE, ST_PSTEP,
        ST_VENTER, ST_VSEEK, ST_READ, ST_RSTEP, ST_FINISH
    } phase_e;

    function automatic logic closes_group(input int unsigned idx);
        return (idx % GROUP_WORDS) == GROUP_WORDS - 1;
    endfunction

endpackage

// File: rtl/rp_issuer.sv
module rp_issuer
    import rowprog_pkg::*;
#(
    parameter int GAP_HI = 20,
    parameter int GAP_LO = 200
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sup_lo,
    input  logic  go,
    input  xfer_t want,
    input  logic  ack,
    output logic  rdy,
    output logic  req,
    output xfer_t cur
);
    localparam int GMAX = (GAP_HI > GAP_LO) ? GAP_HI : GAP_LO;
    localparam int GW   = $clog2(GMAX + 1);

    logic [GW-1:0] gap;

    assign rdy = !req && (gap == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            cur <= '0;
            gap <= '0;
        end else if (req && ack) begin
            req <= 1'b0;
            gap <= sup_lo ? GW'(GAP_LO) : GW'(GAP_HI);
        end else if (go && rdy) begin
            req <= 1'b1;
            cur <= want;
        end else if (gap != '0) begin
            gap <= gap - 1'b1;
        end
    end
endmodule

// File: rtl/rp_timer.sv
module rp_timer #(
    parameter int TICK_DIV = 200,
    parameter int TICKS_HI = 1000,
    parameter int TICKS_LO = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic sup_lo,
    output logic running
);
    localparam int PW   = $clog2(TICK_DIV + 1);
    localparam int TMAX = (TICKS_HI > TICKS_LO) ? TICKS_HI : TICKS_LO;
    localparam int TW   = $clog2(TMAX + 1);

    logic [PW-1:0] pre;
    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pre     <= '0;
            left    <= '0;
        end else if (fire) begin
            running <= 1'b1;
            pre     <= PW'(TICK_DIV - 1);
            left    <= sup_lo ? TW'(TICKS_LO) : TW'(TICKS_HI);
        end else if (running) begin
            if (pre == '0) begin
                pre  <= PW'(TICK_DIV - 1);
                left <= left - 1'b1;
                if (left == TW'(1)) running <= 1'b0;
            end else begin
                pre <= pre - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rp_cursor.sv
module rp_cursor #(
    parameter  int ADDR_W    = 13,
    parameter  int ROW_WORDS = 32,
    localparam int IDX_W     = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seek_load,
    input  logic [ADDR_W-1:0] seek_from,
    input  logic              seek_dec,
    output logic              seek_zero,
    input  logic              idx_clr,
    input  logic              idx_inc,
    output logic [IDX_W-1:0]  idx,
    output logic              idx_last
);
    logic [ADDR_W-1:0] seek;

    assign seek_zero = (seek == '0);
    assign idx_last  = (idx == IDX_W'(ROW_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            seek <= '0;
            idx  <= '0;
        end else begin
            if (seek_load)                  seek <= seek_from;
            else if (seek_dec && !seek_zero) seek <= seek - 1'b1;
            if (idx_clr)      idx <= '0;
            else if (idx_inc) idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/rowprog_seq.sv
module rowprog_seq
    import rowprog_pkg::*;
#(
    parameter  int ADDR_W    = 13,
    parameter  int ROW_WORDS = 32,
    parameter  int TICK_DIV  = 200,
    parameter  int TICKS_HI  = 1000,
    parameter  int TICKS_LO  = 2000,
    parameter  int GAP_HI    = 20,
    parameter  int GAP_LO    = 200,
    localparam int IDX_W     = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic              low_vdd,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [13:0]       buf_word,
    output logic              reenter_req,
    input  logic              reenter_ack,
    output logic              drv_req,
    output logic [5:0]        drv_op,
    output logic [13:0]       drv_arg,
    input  logic              drv_ack,
    input  logic [13:0]       drv_rdata,
    output logic              busy,
    output logic              done,
    output logic              verify_err,
    output logic [ADDR_W-1:0] fail_addr
);
    phase_e            st, st_n;
    logic              sup_lo;
    logic [ADDR_W-1:0] base_q;

    logic  go, rdy, got, tmr_fire, tmr_run;
    logic  seek_load, seek_dec, seek_zero;
    logic  idx_clr, idx_inc, idx_last, set_fail;
    logic [IDX_W-1:0] idx;
    xfer_t want, cur;

    rp_issuer #(.GAP_HI(GAP_HI), .GAP_LO(GAP_LO)) u_issue (
        .clk(clk), .rst(rst), .sup_lo(sup_lo), .go(go), .want(want),
        .ack(drv_ack), .rdy(rdy), .req(drv_req), .cur(cur)
    );

    rp_timer #(.TICK_DIV(TICK_DIV), .TICKS_HI(TICKS_HI), .TICKS_LO(TICKS_LO)) u_wait (
        .clk(clk), .rst(rst), .fire(tmr_fire), .sup_lo(sup_lo), .running(tmr_run)
    );

    rp_cursor #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS)) u_cur (
        .clk(clk), .rst(rst), .seek_load(seek_load), .seek_from(base_q),
        .seek_dec(seek_dec), .seek_zero(seek_zero), .idx_clr(idx_clr),
        .idx_inc(idx_inc), .idx(idx), .idx_last(idx_last)
    );

    assign got         = drv_req && drv_ack;
    assign drv_op      = cur.op;
    assign drv_arg     = cur.arg;
    assign buf_idx     = idx;
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_FINISH);
    assign reenter_req = (st == ST_ENTER) || (st == ST_VENTER);

    always_comb begin
        st_n      = st;
        go        = 1'b0;
        want.op   = OP_INCR;
        want.arg  = '0;
        tmr_fire  = 1'b0;
        seek_load = 1'b0;
        seek_dec  = 1'b0;
        idx_clr   = 1'b0;
        idx_inc   = 1'b0;
        set_fail  = 1'b0;
        unique case (st)
            ST_IDLE:   if (start) st_n = ST_ENTER;
            ST_ENTER:  if (reenter_ack) st_n = ST_PRIME;
            ST_PRIME: begin
                want.op  = OP_LOAD;
                want.arg = '1;
                go       = 1'b1;
                if (got) begin
                    seek_load = 1'b1;
                    st_n      = ST_SEEK;
                end
            end
            ST_SEEK, ST_VSEEK: begin
                if (seek_zero) begin
                    st_n = (st == ST_SEEK) ? ST_ERASE : ST_READ;
                end else begin
                    go       = 1'b1;
                    seek_dec = got;
                end
            end
            ST_ERASE: begin
                want.op = OP_ERASE;
                go      = 1'b1;
                if (got) begin
                    tmr_fire = 1'b1;
                    st_n     = ST_EWAIT;
                end
            end
            ST_EWAIT:  if (!tmr_run) st_n = ST_ECLOSE;
            ST_ECLOSE: begin
                want.op = OP_STOP;
                go      = 1'b1;
                if (got) begin
                    idx_clr = 1'b1;
                    st_n    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                want.op  = OP_LOAD;
                want.arg = buf_word;
                go       = 1'b1;
                if (got) st_n = closes_group(32'(idx)) ? ST_PROG : ST_LSTEP;
            end
            ST_LSTEP: begin
                go = 1'b1;
                if (got) begin
                    idx_inc = 1'b1;
                    st_n    = ST_LOAD;
                end
            end
            ST_PROG: begin
                want.op = OP_PROG;
                go      = 1'b1;
                if (got) begin
                    tmr_fire = 1'b1;
                    st_n     = ST_PWAIT;
                end
            end
            ST_PWAIT:  if (!tmr_run) st_n = ST_PCLOSE;
            ST_PCLOSE: begin
                want.op = OP_STOP;
                go      = 1'b1;
                if (got) st_n = ST_PSTEP;
            end
            ST_PSTEP: begin
                go = 1'b1;
                if (got) begin
                    if (idx_last) begin
                        st_n = ST_VENTER;
                    end else begin
                        idx_inc = 1'b1;
                        st_n    = ST_LOAD;
                    end
                end
            end
            ST_VENTER: begin
                if (reenter_ack) begin
                    seek_load = 1'b1;
                    idx_clr   = 1'b1;
                    st_n      = ST_VSEEK;
                end
            end
            ST_READ: begin
                want.op = OP_READ;
                go      = 1'b1;
                if (got) begin
                    if (drv_rdata != buf_word) begin
                        set_fail = 1'b1;
                        st_n     = ST_FINISH;
                    end else begin
                        st_n = idx_last ? ST_FINISH : ST_RSTEP;
                    end
                end
            end
            ST_RSTEP: begin
                go = 1'b1;
                if (got) begin
                    idx_inc = 1'b1;
                    st_n    = ST_READ;
                end
            end
            ST_FINISH: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            sup_lo     <= 1'b0;
            base_q     <= '0;
            verify_err <= 1'b0;
            fail_addr  <= '0;
        end else begin
            st <= st_n;
            if (st == ST_IDLE && start) begin
                sup_lo     <= low_vdd;
                base_q     <= {row_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
                verify_err <= 1'b0;
                fail_addr  <= '0;
            end
            if (set_fail) begin
                verify_err <= 1'b1;
                fail_addr  <= base_q + ADDR_W'(idx);
            end
        end
    end
endmodule

// File: rtl/rowprog_chk.sv
module rowprog_chk
    import rowprog_pkg::*;
#(
    parameter int TICK_DIV = 200,
    parameter int TICKS_HI = 1000,
    parameter int TICKS_LO = 2000,
    parameter int GAP_HI   = 20,
    parameter int GAP_LO   = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       low_vdd,
    input logic       busy,
    input logic       done,
    input logic       drv_req,
    input logic       drv_ack,
    input logic [5:0] drv_op,
    input logic [13:0] drv_arg,
    input logic       reenter_req,
    input logic       reenter_ack
);
    logic [31:0] low_cnt, gap_need, wait_need;
    logic        fresh, last_timed;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt    <= '0;
            gap_need   <= '0;
            wait_need  <= '0;
            fresh      <= 1'b1;
            last_timed <= 1'b0;
        end else begin
            if (!busy && start) begin
                gap_need  <= low_vdd ? 32'(GAP_LO) : 32'(GAP_HI);
                wait_need <= low_vdd ? 32'(TICKS_LO * TICK_DIV) : 32'(TICKS_HI * TICK_DIV);
            end
            if (drv_req && drv_ack) begin
                low_cnt    <= '0;
                last_timed <= (drv_op == OP_ERASE) || (drv_op == OP_PROG);
                fresh      <= 1'b0;
            end else if (!drv_req && low_cnt != '1) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (reenter_ack) fresh <= 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drv_req && !reenter_req);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        drv_req && !drv_ack |=> drv_req && $stable(drv_op) && $stable(drv_arg));

    // R7
    cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_req) && !fresh && !last_timed |-> low_cnt >= gap_need);

    // R6
    wait_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_req) && !fresh && last_timed |-> low_cnt >= wait_need && drv_op == OP_STOP);

    // R9
    reenter_excl_chk: assert property (@(posedge clk) disable iff (rst)
        reenter_req |-> !drv_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
endmodule

bind rowprog_seq rowprog_chk #(
    .TICK_DIV(TICK_DIV), .TICKS_HI(TICKS_HI), .TICKS_LO(TICKS_LO),
    .GAP_HI(GAP_HI), .GAP_LO(GAP_LO)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .low_vdd(low_vdd), .busy(busy),
    .done(done), .drv_req(drv_req), .drv_ack(drv_ack), .drv_op(drv_op),
    .drv_arg(drv_arg), .reenter_req(reenter_req), .reenter_ack(reenter_ack)
);

// File: tb/sim_rowprog_seq.sv
`timescale 1ns/100ps
module sim_rowprog_seq;
    import rowprog_pkg::*;

    localparam int AW = 13, DIV = 4, THI = 3, TLO = 5, GHI = 2, GLO = 5;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0, low_vdd = 1'b0;
    logic [AW-1:0] row_addr = '0;
    logic [4:0]    buf_idx;
    logic [13:0]   buf_word;
    logic          reenter_req, reenter_ack = 1'b0;
    logic          drv_req, drv_ack = 1'b0;
    logic [5:0]    drv_op;
    logic [13:0]   drv_arg, drv_rdata = '0;
    logic          busy, done, verify_err;
    logic [AW-1:0] fail_addr;

    always #2.5 clk = ~clk;

    rowprog_seq #(.ADDR_W(AW), .ROW_WORDS(32), .TICK_DIV(DIV), .TICKS_HI(THI),
                  .TICKS_LO(TLO), .GAP_HI(GHI), .GAP_LO(GLO)) u0 (
        .clk(clk), .rst(rst), .start(start), .row_addr(row_addr), .low_vdd(low_vdd),
        .buf_idx(buf_idx), .buf_word(buf_word), .reenter_req(reenter_req),
        .reenter_ack(reenter_ack), .drv_req(drv_req), .drv_op(drv_op),
        .drv_arg(drv_arg), .drv_ack(drv_ack), .drv_rdata(drv_rdata),
        .busy(busy), .done(done), .verify_err(verify_err), .fail_addr(fail_addr)
    );

    logic [13:0] bufm [32];
    logic [13:0] tgt  [128];
    assign buf_word = bufm[buf_idx];

    logic [20:0] expq[$];
    string       tagq[$];
    int tests = 0, fails = 0, cyc = 0;
    int fault_at = -1, ptr = 0, svc_left = 0, low_cnt = 0;
    int gap_need = GHI, wait_need = THI * DIV;
    bit last_was_reent = 1'b1, exp_busy = 1'b0;
    logic [5:0]  last_op = '0;
    logic [20:0] svc_item, act_item;
    string       cur_tag;

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [20:0] item, string tag);
        expq.push_back(item);
        tagq.push_back(tag);
    endtask

    // behavioural busy model
    always @(posedge clk) begin
        if (rst)        exp_busy <= 1'b0;
        else if (done)  exp_busy <= 1'b0;
        else if (start) exp_busy <= 1'b1;
    end

    // serial driver + target model, compared every clock
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            svc_left = 0; low_cnt = 0; last_was_reent = 1'b1;
            drv_ack = 1'b0; reenter_ack = 1'b0;
        end else begin
            drv_ack = 1'b0; reenter_ack = 1'b0;
            check(busy === exp_busy, "R2", "busy tracks accepted start", int'(busy), int'(exp_busy));
            if (svc_left > 0) begin
                svc_left--;
                act_item = reenter_req ? 21'h100000 : {1'b0, drv_op, drv_arg};
                check(act_item === svc_item && (reenter_req || drv_req), "R8",
                      "request held until ack", int'(act_item), int'(svc_item));
                if (svc_left == 0) begin
                    if (svc_item[20]) begin
                        ptr = 0;
                        reenter_ack = 1'b1;
                    end else begin
                        case (svc_item[19:14])
                            OP_INCR:  ptr = (ptr + 1) % 128;
                            OP_LOAD:  tgt[ptr] = svc_item[13:0];
                            OP_ERASE: for (int i = 0; i < 32; i++) tgt[(ptr & ~31) + i] = 14'h3FFF;
                            OP_READ:  drv_rdata = tgt[ptr] ^ ((ptr == fault_at) ? 14'h0004 : 14'h0000);
                            default: ;
                        endcase
                        drv_ack = 1'b1;
                    end
                end
            end else if (drv_req || reenter_req) begin
                act_item = reenter_req ? 21'h100000 : {1'b0, drv_op, drv_arg};
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "command after end of sequence", int'(act_item), 0);
                end else begin
                    cur_tag = tagq.pop_front();
                    check(act_item === expq[0], cur_tag, "command order/content",
                          int'(act_item), int'(expq[0]));
                    void'(expq.pop_front());
                end
                if (!reenter_req && !last_was_reent) begin
                    if (last_op == OP_ERASE || last_op == OP_PROG)
                        check(low_cnt >= wait_need && low_cnt <= wait_need + 3, "R6",
                              "timed wait length", low_cnt, wait_need);
                    else
                        check(low_cnt >= gap_need && low_cnt <= gap_need + 3, "R7",
                              "command gap", low_cnt, gap_need);
                end
                last_was_reent = reenter_req;
                last_op  = drv_op;
                svc_item = act_item;
                svc_left = 3;
                low_cnt  = 0;
            end else begin
                low_cnt++;
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic build(int base, int fault_idx);
        expq.delete(); tagq.delete();
        push(21'h100000, "R3");
        push({1'b0, OP_LOAD, 14'h3FFF}, "R3");
        for (int i = 0; i < base; i++) push({1'b0, OP_INCR, 14'h0}, "R3");
        push({1'b0, OP_ERASE, 14'h0}, "R4");
        push({1'b0, OP_STOP, 14'h0}, "R4");
        for (int w = 0; w < 32; w++) begin
            push({1'b0, OP_LOAD, bufm[w]}, "R5");
            if (w % 4 != 3) begin
                push({1'b0, OP_INCR, 14'h0}, "R5");
            end else begin
                push({1'b0, OP_PROG, 14'h0}, "R5");
                push({1'b0, OP_STOP, 14'h0}, "R5");
                push({1'b0, OP_INCR, 14'h0}, "R5");
            end
        end
        push(21'h100000, "R9");
        for (int i = 0; i < base; i++) push({1'b0, OP_INCR, 14'h0}, "R9");
        for (int w = 0; w < 32; w++) begin
            push({1'b0, OP_READ, 14'h0}, "R9");
            if (w == fault_idx) break;
            if (w < 31) push({1'b0, OP_INCR, 14'h0}, "R9");
        end
    endtask

    task automatic run(int addr, bit lowv, int fault_abs, bit poke, int seed);
        int base = addr & ~31;
        int t = 0;
        for (int w = 0; w < 32; w++) bufm[w] = 14'((w * 37 + seed * 101) ^ 14'h2A5A);
        fault_at  = fault_abs;
        gap_need  = lowv ? GLO : GHI;
        wait_need = (lowv ? TLO : THI) * DIV;
        build(base, fault_abs < 0 ? -1 : fault_abs - base);
        @(negedge clk);
        row_addr = AW'(addr); low_vdd = lowv; start = 1'b1;
        @(negedge clk);
        start = 1'b0; low_vdd = ~lowv; row_addr = AW'(addr ^ 13'h0A0);
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke && t == 300) begin start = 1'b1; row_addr = '0; end   // R2
            if (poke && t == 301) start = 1'b0;
        end
        check(done === 1'b1, "R11", "run reached done", int'(done), 1);
        if (fault_abs < 0) begin
            check(verify_err === 1'b0, "R11", "no verify error", int'(verify_err), 0);
        end else begin
            check(verify_err === 1'b1, "R10", "verify error flagged", int'(verify_err), 1);
            check(fail_addr === AW'(fault_abs), "R10", "failing address", int'(fail_addr), fault_abs);
        end
        check(expq.size() == 0, "R9", "all expected commands issued", expq.size(), 0);
        repeat (30) @(negedge clk);
        check(!drv_req && !reenter_req && !busy, "R10", "quiet after run",
              int'({drv_req, reenter_req, busy}), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) tgt[i] = 14'h3FFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", int'({busy, done}), 0);
        check(drv_req === 1'b0 && reenter_req === 1'b0, "R1", "no request after reset",
              int'({drv_req, reenter_req}), 0);
        check(verify_err === 1'b0, "R1", "no error after reset", int'(verify_err), 0);
        run(32, 1'b0, -1, 1'b0, 1);        // R3 R4 R5 R6 R7 R11, high supply
        run(69, 1'b1, -1, 1'b1, 2);        // R2 R3 low bits ignored, low supply, start poked mid-run
        run(96, 1'b0, 96 + 13, 1'b0, 3);   // R10 mid-row mismatch
        run(0, 1'b1, 31, 1'b0, 4);         // R10 last word mismatch
        run(64, 1'b0, 64, 1'b0, 5);        // R10 first word mismatch
        run(0, 1'b0, -1, 1'b0, 6);         // R11 clean row at base zero
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule